// File: doc/BRIEF.md
# Serial Link Frame Transmitter

This block turns a stream of 32-bit user words into framed traffic for an 8B/10B serial link. Each frame opens with one of eight start codes. The choice of start code encodes three sideband bits: two programmed-I/O bits and a direction bit. The user words follow. After the last word the block sends one of four status codes, which encodes a not-ready bit and a transmit-overflow bit. A closing code then tells the receiver whether the frame carries a sync marker.

Idle words fill the link whenever there is no frame to send. A payload-length parameter splits long input blocks into several frames, so that an idle word always appears within the required spacing. The output is one 32-bit word per cycle plus a control flag. When the flag is set, the low byte holds a symbolic ordered-set code and the upper 24 bits are zero. The 8B/10B encoder maps these codes to real K-characters downstream.

Top module: `sfl_tx_framer`

## Requirements
- R1: After reset the output is the idle ordered set (`out_ctrl`=1, `out_word`=0x00000000), and `in_ready` is low until a start code has been issued.
- R2: When `in_valid` is high between frames, the next output is a start code 0x10 + {pio1, pio2, dir} with `out_ctrl`=1, where dir = NOT `in_dir_n`. The sideband is taken from the first word of the frame, which is held on the input.
- R3: A word accepted (`in_valid` and `in_ready`) appears on `out_word` with `out_ctrl`=0 in the following cycle. Words leave in the order they were accepted.
- R4: The cycle after a frame's final data word, the output is the status code 0x20 + {nrdy, ovf}, where nrdy = NOT `in_nrdy_n`. Both bits are sampled with that final word.
- R5: The cycle after the status code, the output is the closing code: 0x31 if `in_sync` was high on the final word, otherwise 0x30.
- R6: The cycle after a closing code, the output is always idle. `in_ready` stays low from the acceptance of a frame's final word until the next start code has been issued.
- R7: When a frame reaches MAX_PAYLOAD words without `in_last`, the frame is closed (status code, then closing code 0x30 unless the closing word had `in_sync`). The remaining words go out in a new frame with its own start code.
- R8: If `in_valid` drops inside a frame, the framer sends idle words. It does not send a status code, and the frame resumes with the next word.
- R9: The output never carries more than IDLE_SPACING-1 non-idle words in a row. Elaboration rejects any MAX_PAYLOAD with MAX_PAYLOAD+3 >= IDLE_SPACING.
- R10: With no input pending, the output is a continuous run of idle words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Framer accepts the word this cycle |
| in_data | input | 32 | User data word |
| in_last | input | 1 | Word ends the user block |
| in_sync | input | 1 | Mark the frame closed by this word as sync-marked |
| in_pio1 | input | 1 | Sideband bit 1, taken on the first word |
| in_pio2 | input | 1 | Sideband bit 2, taken on the first word |
| in_dir_n | input | 1 | Direction, active low, taken on the first word |
| in_nrdy_n | input | 1 | Not-ready, active low, taken on the closing word |
| in_fifo_ovf | input | 1 | Overflow flag, taken on the closing word |
| out_word | output | 32 | Link word: user data or symbolic ordered-set code |
| out_ctrl | output | 1 | High when out_word is an ordered set |

## Verification
The bench sweeps all eight sideband combinations, all four status combinations and both sync settings, with frame lengths that fall below, at and above the payload limit. Several hazards are targeted:
- If a split happens one word early or late, the status code shows up in the wrong position.
- A polarity slip on the direction or not-ready input shows up as the wrong start or status code.
- Sampling sync on every word, rather than on the closing word, marks the split-off segments with 0x31.
- Input bubbles inside a frame must produce idle fill only. A design that closed the frame on a bubble would put a status code out of sequence.
- The word after each closing code and the length of every non-idle run are checked, which catches a missing inter-frame idle.

// File: rtl/sfl_tx_pkg.sv
package sfl_tx_pkg;
   // Symbolic ordered-set codes, carried in the low byte of a control word.
   localparam logic [7:0] OS_IDLE      = 8'h00;
   localparam logic [7:0] OS_SOF_BASE  = 8'h10;  // + {pio1, pio2, dir}
   localparam logic [7:0] OS_STAT_BASE = 8'h20;  // + {nrdy, ovf}
   localparam logic [7:0] OS_CLOSE_FRM = 8'h30;
   localparam logic [7:0] OS_CLOSE_MRK = 8'h31;
   localparam logic [7:0] OS_PAD_BASE  = 8'h40;  // four padding codes, reserved

   // Phase names what the framer will put out next.
   typedef enum logic [1:0] {
      PH_WAIT  = 2'd0,  // idle or start code
      PH_BODY  = 2'd1,  // data, idle fill or status code
      PH_CLOSE = 2'd2,  // closing code
      PH_TAIL  = 2'd3   // mandatory idle after close
   } phase_t;

   function automatic logic [31:0] os_word(input logic [7:0] code);
      return {24'h000000, code};
   endfunction
endpackage

// File: rtl/sfl_code_sel.sv
module sfl_code_sel
   import sfl_tx_pkg::*;
(
   input  logic       pio1,
   input  logic       pio2,
   input  logic       dir_n,
   input  logic       nrdy_n,
   input  logic       fifo_ovf,
   output logic [7:0] sof_code,
   output logic [7:0] stat_code
);
   // Both active-low inputs are sent active high on the link.
   always_comb begin
      sof_code  = OS_SOF_BASE  | {5'b0, pio1, pio2, ~dir_n};
      stat_code = OS_STAT_BASE | {6'b0, ~nrdy_n, fifo_ovf};
   end
endmodule

// File: rtl/sfl_payload_ctr.sv
module sfl_payload_ctr #(
   parameter int MAX_PAYLOAD = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic at_last
);
   localparam int CW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

   generate
      if (MAX_PAYLOAD == 1) begin : g_single
         // Every word fills the frame.
         assign at_last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clear) cnt_q <= '0;
            else if (step)  cnt_q <= cnt_q + 1'b1;
         end
         assign at_last = (cnt_q == CW'(MAX_PAYLOAD - 1));
      end
   endgenerate
endmodule

// File: rtl/sfl_tx_framer.sv
module sfl_tx_framer
   import sfl_tx_pkg::*;
#(
   parameter int MAX_PAYLOAD  = 1024,
   parameter int IDLE_SPACING = 4096
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [31:0] in_data,
   input  logic        in_last,
   input  logic        in_sync,
   input  logic        in_pio1,
   input  logic        in_pio2,
   input  logic        in_dir_n,
   input  logic        in_nrdy_n,
   input  logic        in_fifo_ovf,
   output logic [31:0] out_word,
   output logic        out_ctrl
);
   localparam int RW = $clog2(IDLE_SPACING + 1);

   // Elaboration-time parameter checks (R9)
   if (MAX_PAYLOAD < 1) begin : g_bad_len
      $error("MAX_PAYLOAD must be at least 1");
   end
   if (MAX_PAYLOAD + 3 >= IDLE_SPACING) begin : g_bad_spacing
      $error("MAX_PAYLOAD+3 must stay below IDLE_SPACING");
   end

   phase_t      phase_q;
   logic        closing_q;
   logic        sync_q;
   logic [7:0]  stat_q;
   logic [7:0]  sof_code;
   logic [7:0]  stat_code;
   logic        at_last;
   logic        accept;

   sfl_code_sel u_codes (
      .pio1     (in_pio1),
      .pio2     (in_pio2),
      .dir_n    (in_dir_n),
      .nrdy_n   (in_nrdy_n),
      .fifo_ovf (in_fifo_ovf),
      .sof_code (sof_code),
      .stat_code(stat_code)
   );

   sfl_payload_ctr #(.MAX_PAYLOAD(MAX_PAYLOAD)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (phase_q == PH_WAIT),
      .step   (accept),
      .at_last(at_last)
   );

   assign in_ready = (phase_q == PH_BODY) && !closing_q;
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_WAIT;
         closing_q <= 1'b0;
         sync_q    <= 1'b0;
         stat_q    <= OS_STAT_BASE;
         out_word  <= os_word(OS_IDLE);
         out_ctrl  <= 1'b1;
      end else begin
         case (phase_q)
            PH_WAIT: begin
               out_ctrl <= 1'b1;
               if (in_valid) begin
                  out_word  <= os_word(sof_code);
                  phase_q   <= PH_BODY;
                  closing_q <= 1'b0;
               end else begin
                  out_word <= os_word(OS_IDLE);
               end
            end
            PH_BODY: begin
               if (closing_q) begin
                  out_word <= os_word(stat_q);
                  out_ctrl <= 1'b1;
                  phase_q  <= PH_CLOSE;
               end else if (in_valid) begin
                  out_word  <= in_data;
                  out_ctrl  <= 1'b0;
                  closing_q <= in_last || at_last;
                  stat_q    <= stat_code;
                  sync_q    <= in_sync;
               end else begin
                  out_word <= os_word(OS_IDLE);
                  out_ctrl <= 1'b1;
               end
            end
            PH_CLOSE: begin
               out_word <= os_word(sync_q ? OS_CLOSE_MRK : OS_CLOSE_FRM);
               out_ctrl <= 1'b1;
               phase_q  <= PH_TAIL;
            end
            default: begin
               out_word <= os_word(OS_IDLE);
               out_ctrl <= 1'b1;
               phase_q  <= PH_WAIT;
            end
         endcase
      end
   end

   // Run length of consecutive non-idle output words, for the spacing check.
   logic [RW-1:0] run_q;
   wire out_is_idle  = out_ctrl && (out_word == os_word(OS_IDLE));
   wire out_is_stat  = out_ctrl && (out_word[31:2] == {24'h0, OS_STAT_BASE[7:2]});
   wire out_is_close = out_ctrl && (out_word[31:1] == {24'h0, OS_CLOSE_FRM[7:1]});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run_q <= '0;
      else if (out_is_idle) run_q <= '0;
      else if (run_q != RW'(IDLE_SPACING)) run_q <= run_q + 1'b1;
   end

   assert_data_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (!out_ctrl && out_word == $past(in_data)));

   assert_stat_then_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_stat |=> out_is_close);

   assert_close_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_close |=> out_is_idle);

   assert_no_ready_at_stat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_is_stat |-> !in_ready);

   assert_idle_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run_q < RW'(IDLE_SPACING));
endmodule

// File: tb/sfl_tx_framer_test.sv
module sfl_tx_framer_test;
   localparam int MAXP = 4;
   localparam int SPAC = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_data = '0;
   logic        in_last = 1'b0;
   logic        in_sync = 1'b0;
   logic        in_pio1 = 1'b0;
   logic        in_pio2 = 1'b0;
   logic        in_dir_n = 1'b1;
   logic        in_nrdy_n = 1'b1;
   logic        in_fifo_ovf = 1'b0;
   logic [31:0] out_word;
   logic        out_ctrl;

   int checks = 0;
   int fails  = 0;
   bit mon_on = 1'b0;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   sfl_tx_framer #(.MAX_PAYLOAD(MAXP), .IDLE_SPACING(SPAC)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last), .in_sync(in_sync),
      .in_pio1(in_pio1), .in_pio2(in_pio2), .in_dir_n(in_dir_n),
      .in_nrdy_n(in_nrdy_n), .in_fifo_ovf(in_fifo_ovf),
      .out_word(out_word), .out_ctrl(out_ctrl)
   );

   task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [32:0] v, input string t);
      exp_q.push_back(v);
      tag_q.push_back(t);
   endtask

   // Monitor: compares non-idle words in order, checks idle after close and run length.
   initial begin
      int  run = 0;
      bit  prev_close = 1'b0;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            logic [32:0] cur;
            bit is_idle;
            cur = {out_ctrl, out_word};
            is_idle = (cur == {1'b1, 32'h0});
            if (prev_close) check(is_idle, "R6 idle after close", cur, {1'b1, 32'h0});
            if (is_idle) begin
               if (run > 0) check(run <= SPAC - 1, "R9 non-idle run", 33'(run), 33'(SPAC - 1));
               run = 0;
            end else begin
               run++;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R3 unexpected word", cur, 33'h0);
               end else begin
                  logic [32:0] e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(cur == e, t, cur, e);
               end
            end
            prev_close = out_ctrl && (out_word == 32'h30 || out_word == 32'h31);
         end
      end
   end

   // Build the expected stream from the requirements, then drive the frame.
   task automatic send_frame(input int f, input int len, input logic [2:0] sb,
                             input logic [1:0] st, input bit sync, input bit bubble);
      int seg_start = 0;
      while (seg_start < len) begin
         int seg_len;
         bit final_seg;
         seg_len   = (len - seg_start > MAXP) ? MAXP : len - seg_start;
         final_seg = (seg_start + seg_len == len);
         push({1'b1, 24'h0, 8'h10 | {5'b0, sb}}, "R2 start code");
         for (int k = 0; k < seg_len; k++)
            push({1'b0, 32'hA500_0000 | 32'(f << 8) | 32'(seg_start + k)},
                 bubble ? "R8 data across bubble" : "R3 data word");
         push({1'b1, 24'h0, 8'h20 | {6'b0, st}}, final_seg ? "R4 status code" : "R7 split status code");
         push({1'b1, 24'h0, (final_seg && sync) ? 8'h31 : 8'h30},
              final_seg ? "R5 closing code" : "R7 split closing code");
         seg_start += seg_len;
      end
      for (int k = 0; k < len; k++) begin
         if (bubble && k == 1) begin
            in_valid = 1'b0;
            repeat (2) @(negedge clk);
         end
         in_valid    = 1'b1;
         in_data     = 32'hA500_0000 | 32'(f << 8) | 32'(k);
         in_last     = (k == len - 1);
         in_sync     = sync && (k == len - 1);
         in_pio1     = sb[2];
         in_pio2     = sb[1];
         in_dir_n    = ~sb[0];
         in_nrdy_n   = ~st[1];
         in_fifo_ovf = st[0];
         forever begin
            #1;
            if (in_ready) break;
            @(negedge clk);
         end
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R3 watchdog actual=stalled expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check({out_ctrl, out_word} == {1'b1, 32'h0}, "R1 reset output", {out_ctrl, out_word}, {1'b1, 32'h0});
      check(in_ready == 1'b0, "R1 ready low", 33'(in_ready), 33'h0);
      mon_on = 1'b1;
      for (int f = 0; f < 64; f++) begin
         send_frame(f, 1 + (f % 7), f[2:0], f[4:3], f[5], (f % 3) == 0);
      end
      // Drain: wait until all expected words are seen.
      for (int w = 0; w < 40 && exp_q.size() != 0; w++) @(negedge clk);
      check(exp_q.size() == 0, "R7 all words delivered", 33'(exp_q.size()), 33'h0);
      repeat (3) @(negedge clk);
      // R10: no input gives continuous idle
      for (int w = 0; w < 10; w++) begin
         check({out_ctrl, out_word} == {1'b1, 32'h0}, "R10 idle when empty",
               {out_ctrl, out_word}, {1'b1, 32'h0});
         @(negedge clk);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule